// File: doc/BRIEF.md
# Physical Register Reference Counter

This block keeps a reference count for every physical register in a renaming core. With move elimination, several architectural registers may be mapped onto one physical register. A register can therefore go back to the free list only when its last reference is gone. Each cycle the block takes a set of increment lanes and a set of decrement lanes. Increments come from fresh allocations and from eliminated moves that share an existing register. Decrements come from deallocations at commit. Each lane names one physical register by index.

The block adds up every lane that hits the same register in a cycle and applies the net change to that register's counter. It raises one bit in a per-register release bitmap, one cycle after the requests, for each register whose count fell from a nonzero value to zero. That bitmap feeds the free list. Registers that back the initial architectural mapping start with a count of one. A request that would drive a count below zero is reported on an error output and leaves the counter untouched.

Top module: `prf_refcount`

## Requirements
- R1: After reset, registers 0 to INIT_MAPPED-1 hold a count of one and all other registers hold zero. The release bitmap and the error output read zero.
- R2: Every valid increment lane adds one to the count of the register whose index it carries.
- R3: Every valid decrement lane subtracts one from the count of the register whose index it carries.
- R4: Bit r of `release_o` is 1 in the cycle after a request cycle only if register r's count went from a nonzero value to exactly zero in that request cycle.
- R5: When several increment and decrement lanes target one register in the same cycle, the count changes by their net sum. At most one release bit results for that register, so a cancelling increment/decrement pair produces no release.
- R6: A register whose count stays at zero, or rises from zero, never raises its release bit.
- R7: If the decrements to a register in one cycle exceed its count plus that cycle's increments, `underflow_o` is 1 in the next cycle. That register's count is left unchanged and it raises no release bit.
- R8: Each release bit is a single-cycle pulse, registered one cycle after the requests that caused it.
- R9: A lane whose valid bit is 0 has no effect, whatever index it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_valid_i | input | INC_PORTS | Valid bit per increment lane |
| inc_idx_i | input | INC_PORTS x IDX_W | Register index per increment lane |
| dec_valid_i | input | DEC_PORTS | Valid bit per decrement lane |
| dec_idx_i | input | DEC_PORTS x IDX_W | Register index per decrement lane |
| release_o | output | NUM_PREGS | Per-register release pulse, one cycle after the update |
| underflow_o | output | 1 | A decrement would have driven some count below zero |

## Verification
The bench first drains each register in turn with a single decrement. Registers of the initial mapping must release, and all others must flag underflow. A design with the wrong reset population or a release on a zero-to-zero step shows up here. Directed cycles then aim lanes at the same register: a cancelling increment/decrement pair, three decrements that empty a count of three, and a decrement larger than count plus increments. A design that counts lanes per port instead of per register, or that lets an underflowing counter wrap, gives a wrong bitmap or error bit. A long pseudo-random run over a few heavily colliding indices is then compared cycle by cycle against an arithmetic model of the counts. This catches wrong net sums, stuck release pulses and idle lanes that leak through.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;

    // Outcome of one counter update in a cycle
    typedef enum logic [1:0] {
        RC_HOLD      = 2'd0,
        RC_UPDATE    = 2'd1,
        RC_RELEASE   = 2'd2,
        RC_UNDERFLOW = 2'd3
    } rc_outcome_e;

    // Registered per-register event flags
    typedef struct packed {
        logic rel;
        logic uf;
    } rc_event_t;

    function automatic rc_event_t event_of(input rc_outcome_e oc);
        rc_event_t ev;
        ev.rel = (oc == RC_RELEASE);
        ev.uf  = (oc == RC_UNDERFLOW);
        return ev;
    endfunction

endpackage

// File: rtl/refcnt_match.sv
// Counts, for every physical register, how many valid lanes carry its index.
module refcnt_match #(
    parameter int NUM_PREGS = 64,
    parameter int PORTS     = 4,
    localparam int IDX_W    = $clog2(NUM_PREGS),
    localparam int HIT_W    = $clog2(PORTS + 1)
) (
    input  logic [PORTS-1:0]                valid_i,
    input  logic [PORTS-1:0][IDX_W-1:0]     idx_i,
    output logic [NUM_PREGS-1:0][HIT_W-1:0] hits_o
);

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
        always_comb begin
            hits_o[r] = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (valid_i[p] && (idx_i[p] == IDX_W'(r))) begin
                    hits_o[r] = hits_o[r] + HIT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/refcnt_cell.sv
// One reference counter with release and underflow detection.
module refcnt_cell
    import refcnt_pkg::*;
#(
    parameter int   CNT_W    = 4,
    parameter int   INC_W    = 3,
    parameter int   DEC_W    = 3,
    parameter logic INIT_ONE = 1'b0,
    localparam int  SUM_W    = CNT_W + INC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_n_i,
    input  logic [DEC_W-1:0] dec_n_i,
    output logic             rel_o,
    output logic             uf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] gross;
    logic [SUM_W-1:0] take;
    logic [SUM_W-1:0] remain;
    rc_outcome_e      outcome;
    rc_event_t        ev_d;
    rc_event_t        ev_q;

    always_comb begin
        gross  = SUM_W'(cnt_q) + SUM_W'(inc_n_i);
        take   = SUM_W'(dec_n_i);
        remain = gross - take;
        if (take > gross) begin
            outcome = RC_UNDERFLOW;
        end else if ((inc_n_i == '0) && (dec_n_i == '0)) begin
            outcome = RC_HOLD;
        end else if ((cnt_q != '0) && (remain == '0)) begin
            outcome = RC_RELEASE;
        end else begin
            outcome = RC_UPDATE;
        end
        ev_d = event_of(outcome);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= INIT_ONE ? CNT_W'(1) : '0;
            ev_q  <= '0;
        end else begin
            if ((outcome == RC_UPDATE) || (outcome == RC_RELEASE)) begin
                cnt_q <= remain[CNT_W-1:0];
            end
            ev_q <= ev_d;
        end
    end

    assign rel_o = ev_q.rel;
    assign uf_o  = ev_q.uf;

    // R4
    release_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.rel |-> ((cnt_q == '0) && ($past(cnt_q) != '0)));

    // R6
    no_release_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == '0) |-> !ev_q.rel);

    // R7
    underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.uf |-> ($stable(cnt_q) && !ev_q.rel));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.rel |=> !ev_q.rel);

endmodule

// File: rtl/prf_refcount.sv
module prf_refcount #(
    parameter int  NUM_PREGS   = 64,
    parameter int  INIT_MAPPED = 32,
    parameter int  INC_PORTS   = 4,
    parameter int  DEC_PORTS   = 4,
    parameter int  MAX_REFS    = 8,
    localparam int IDX_W       = $clog2(NUM_PREGS),
    localparam int CNT_W       = $clog2(MAX_REFS) + 1,
    localparam int INC_W       = $clog2(INC_PORTS + 1),
    localparam int DEC_W       = $clog2(DEC_PORTS + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [INC_PORTS-1:0]            inc_valid_i,
    input  logic [INC_PORTS-1:0][IDX_W-1:0] inc_idx_i,
    input  logic [DEC_PORTS-1:0]            dec_valid_i,
    input  logic [DEC_PORTS-1:0][IDX_W-1:0] dec_idx_i,
    output logic [NUM_PREGS-1:0]            release_o,
    output logic                            underflow_o
);

    logic [NUM_PREGS-1:0][INC_W-1:0] inc_hits;
    logic [NUM_PREGS-1:0][DEC_W-1:0] dec_hits;
    logic [NUM_PREGS-1:0]            uf_vec;

    refcnt_match #(.NUM_PREGS(NUM_PREGS), .PORTS(INC_PORTS)) u_inc_match (
        .valid_i (inc_valid_i),
        .idx_i   (inc_idx_i),
        .hits_o  (inc_hits)
    );

    refcnt_match #(.NUM_PREGS(NUM_PREGS), .PORTS(DEC_PORTS)) u_dec_match (
        .valid_i (dec_valid_i),
        .idx_i   (dec_idx_i),
        .hits_o  (dec_hits)
    );

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_cell
        refcnt_cell #(
            .CNT_W    (CNT_W),
            .INC_W    (INC_W),
            .DEC_W    (DEC_W),
            .INIT_ONE (r < INIT_MAPPED)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .inc_n_i (inc_hits[r]),
            .dec_n_i (dec_hits[r]),
            .rel_o   (release_o[r]),
            .uf_o    (uf_vec[r])
        );
    end

    assign underflow_o = |uf_vec;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> ((release_o == '0) && !underflow_o));

endmodule

// File: tb/prf_refcount_tb.sv
module prf_refcount_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 64;
    localparam int NI  = 32;
    localparam int IP  = 4;
    localparam int DP  = 4;
    localparam int MR  = 8;
    localparam int IW  = $clog2(NP);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [IP-1:0]           inc_valid_i = '0;
    logic [IP-1:0][IW-1:0]   inc_idx_i = '0;
    logic [DP-1:0]           dec_valid_i = '0;
    logic [DP-1:0][IW-1:0]   dec_idx_i = '0;
    logic [NP-1:0]           release_o;
    logic                    underflow_o;

    int checks = 0;
    int failures = 0;
    int model [NP];
    logic [31:0] lfsr = 32'h1ACE_B00F;

    always #(CLK_PERIOD/2) clk = ~clk;

    prf_refcount #(
        .NUM_PREGS(NP), .INIT_MAPPED(NI), .INC_PORTS(IP),
        .DEC_PORTS(DP), .MAX_REFS(MR)
    ) u_dut (
        .clk(clk), .rst(rst),
        .inc_valid_i(inc_valid_i), .inc_idx_i(inc_idx_i),
        .dec_valid_i(dec_valid_i), .dec_idx_i(dec_idx_i),
        .release_o(release_o), .underflow_o(underflow_o)
    );

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic clear_lanes;
        inc_valid_i = '0; inc_idx_i = '0;
        dec_valid_i = '0; dec_idx_i = '0;
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Apply current lanes for one cycle, then compare against the model.
    task automatic step(input string tag);
        logic [NP-1:0] exp_rel;
        logic          exp_uf;
        int            nxt [NP];
        exp_rel = '0;
        exp_uf  = 1'b0;
        for (int r = 0; r < NP; r++) begin
            int up = 0;
            int dn = 0;
            for (int p = 0; p < IP; p++)
                if (inc_valid_i[p] && int'(inc_idx_i[p]) == r) up++;
            for (int p = 0; p < DP; p++)
                if (dec_valid_i[p] && int'(dec_idx_i[p]) == r) dn++;
            nxt[r] = model[r];
            if (model[r] + up - dn < 0) begin
                exp_uf = 1'b1;
            end else begin
                nxt[r] = model[r] + up - dn;
                if (model[r] != 0 && nxt[r] == 0) exp_rel[r] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (release_o !== exp_rel) begin
            failures++;
            $display("FAIL %s release_o actual=%h expected=%h", tag, release_o, exp_rel);
        end
        checks++;
        if (underflow_o !== exp_uf) begin
            failures++;
            $display("FAIL %s underflow_o actual=%b expected=%b", tag, underflow_o, exp_uf);
        end
        for (int r = 0; r < NP; r++) model[r] = nxt[r];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        clear_lanes();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: quiet outputs after reset
        checks++;
        if (release_o !== '0 || underflow_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%h/%b expected=0/0", release_o, underflow_o);
        end
        for (int r = 0; r < NP; r++) model[r] = (r < NI) ? 1 : 0;

        // R1 R3 R4 R7: drain every register once
        for (int r = 0; r < NP; r++) begin
            clear_lanes();
            dec_valid_i[0] = 1'b1;
            dec_idx_i[0]   = IW'(r);
            step(r < NI ? "R1 R4 drain mapped" : "R1 R7 drain unmapped");
        end
        clear_lanes();
        step("R8 idle after drain");

        // R9: invalid lanes carrying indices have no effect
        inc_idx_i = {IW'(5), IW'(5), IW'(5), IW'(5)};
        dec_idx_i = {IW'(9), IW'(9), IW'(9), IW'(9)};
        step("R9 invalid lanes");
        clear_lanes();
        dec_valid_i[1] = 1'b1; dec_idx_i[1] = IW'(5);
        step("R9 reg5 still zero");

        // R2 R6: rise from zero, no release
        clear_lanes();
        inc_valid_i = 4'b0111;
        inc_idx_i   = {IW'(0), IW'(3), IW'(3), IW'(3)};
        step("R2 R6 rise from zero");
        // R5: cancelling pair on reg 3
        clear_lanes();
        inc_valid_i[2] = 1'b1; inc_idx_i[2] = IW'(3);
        dec_valid_i[0] = 1'b1; dec_idx_i[0] = IW'(3);
        step("R5 cancel pair");
        // R5: three decrements empty reg 3, single release
        clear_lanes();
        dec_valid_i = 4'b1011;
        dec_idx_i   = {IW'(3), IW'(0), IW'(3), IW'(3)};
        step("R5 merged release");
        // R7: excess decrement with increment present
        clear_lanes();
        inc_valid_i[0] = 1'b1; inc_idx_i[0] = IW'(7);
        dec_valid_i    = 4'b0011;
        dec_idx_i      = {IW'(0), IW'(0), IW'(7), IW'(7)};
        step("R7 excess decrement");
        clear_lanes();
        inc_valid_i[3] = 1'b1; inc_idx_i[3] = IW'(7);
        step("R7 count held at zero");
        clear_lanes();
        dec_valid_i[3] = 1'b1; dec_idx_i[3] = IW'(7);
        step("R4 release after hold");

        // R2 R3 R5 R8: pseudo-random colliding traffic
        for (int c = 0; c < 3000; c++) begin
            clear_lanes();
            for (int p = 0; p < IP; p++) begin
                lfsr = next_rand(lfsr);
                inc_idx_i[p]   = IW'(lfsr[2:0] + 3'd2);
                inc_valid_i[p] = lfsr[5] & (model[int'(inc_idx_i[p])] <= MR - IP);
            end
            for (int p = 0; p < DP; p++) begin
                lfsr = next_rand(lfsr);
                dec_idx_i[p]   = IW'(lfsr[2:0] + 3'd2);
                dec_valid_i[p] = lfsr[6] & (lfsr[9:8] != 2'b00);
            end
            step("R2 R3 R5 R8 random");
        end

        clear_lanes();
        step("R8 final idle");
        report();
    end

endmodule